// File: doc/BRIEF.md
# Memory Error Capture and Injection Unit

This unit sits next to the ECC logic of a DRAM controller and handles what happens around error detection rather than the detection itself. An external checker reports each completed read with strobes that mark a correctable (single-bit) or an uncorrectable (multi-bit) error, along with the read's data, check bits and address. The unit turns those strobes into sticky flags, counts correctable errors against a programmable threshold, freezes a snapshot of the first failing read, and raises an interrupt line from per-type enables.

On the write side, the unit can corrupt outgoing data on purpose. Software loads a 64-bit data flip mask (split into upper and lower 32-bit words) and a check-bit flip mask. While the inject enable bit is set, every write beat leaving the unit is XORed with those masks. This lets software provoke known error patterns and confirm that the reporting path behaves.

All control and status is reached over a simple 32-bit register bus with a 4-bit word address, single-cycle writes and reads that return data one cycle after the request.

Top module: `mem_err_unit`

## Requirements
- R1: The upper data mask (address 0), the lower data mask (address 1) and the injection control register (address 2: check-bit mask in bits 15:0, inject enable in bit 16) read back the values last written to them and are zero after reset.
- R2: Each write beat appears at the write outputs one cycle after it enters, with the same valid. When inject enable is 1, the data leaves XORed with {upper mask, lower mask} and the check bits leave XORed with the check-bit mask. When inject enable is 0, data and check bits leave unchanged.
- R3: The detect register (address 3) holds a sticky correctable flag in bit 0 and an uncorrectable flag in bit 1. Writing a 1 to a bit clears it and writing a 0 leaves it alone, so writing all ones clears both. If an error sets a flag in the same cycle that a write clears it, the flag ends up set.
- R4: The detect-disable register (address 4, bit 0 correctable, bit 1 uncorrectable) suppresses flagging, counting and capture for that error type. Writing 0 to it turns all detection back on. Its reset value is 0.
- R5: The interrupt enable register (address 5, bit 0 correctable, bit 1 uncorrectable) gates the flags onto irq. irq is 1 in the cycle after some flag and its enable are both 1, and 0 in the cycle after no such pair exists.
- R6: The correctable threshold sits in bits 23:16 of address 6 and the running count in bits 7:0. Both are written together from the same word. Each correctable error that is not disabled adds one to the count. When the count reaches the threshold, the correctable flag is set and the count returns to 0. A threshold of 0 or 1 flags every correctable error.
- R7: An uncorrectable error that is not disabled sets its flag on the next clock, whatever the counter holds.
- R8: When an error sets a flag while both flags are clear, the unit captures that read's data, check bits and address: data upper word at 7, data lower word at 8, address lower word at 10, address upper word at 11. While any flag is set, the capture registers do not change. Writes to capture addresses have no effect.
- R9: The captured check field (address 9) keeps all 16 check bits when the bus-width input selects a 32-bit data bus. When it selects a 64-bit data bus, only the low 8 bits are kept and bits 15:8 read as 0.
- R10: A read request returns its register on reg_rdata in the following cycle. Addresses 12 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus32 | input | 1 | 1: 32-bit data bus configured (16-bit check field) |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| wr_valid_in | input | 1 | Write beat valid from controller |
| wr_data_in | input | 64 | Write data from controller |
| wr_chk_in | input | 16 | Write check bits from controller |
| wr_valid_out | output | 1 | Write beat valid toward memory |
| wr_data_out | output | 64 | Write data after injection |
| wr_chk_out | output | 16 | Check bits after injection |
| chk_valid | input | 1 | A checked read completed |
| chk_sbe | input | 1 | That read had a correctable error |
| chk_mbe | input | 1 | That read had an uncorrectable error |
| chk_data | input | 64 | Data of that read |
| chk_ecc | input | 16 | Check bits of that read |
| chk_addr | input | 64 | Address of that read |
| irq | output | 1 | Error interrupt |

## Verification
Correctable errors are sent in bursts against thresholds of 3, 1 and 0. This shows whether flagging happens on reaching the threshold or one error later, and whether the count resets afterwards. Errors that arrive while a flag is set, and others that arrive after a clear, show whether capture stays frozen and then re-arms correctly. A write to the detect register in the same cycle as a new error shows which of the two wins. Write beats pass through with injection off and then on, using asymmetric masks in each half. Captures are taken under both bus-width settings, which shows whether the check-field masking is applied in the right mode.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;
  localparam int REG_AW  = 4;
  localparam int THR_LSB = 16;

  localparam logic [REG_AW-1:0] A_MASK_HI  = 4'd0;
  localparam logic [REG_AW-1:0] A_MASK_LO  = 4'd1;
  localparam logic [REG_AW-1:0] A_INJ_CTL  = 4'd2;
  localparam logic [REG_AW-1:0] A_DETECT   = 4'd3;
  localparam logic [REG_AW-1:0] A_DISABLE  = 4'd4;
  localparam logic [REG_AW-1:0] A_IRQ_EN   = 4'd5;
  localparam logic [REG_AW-1:0] A_SBE_MGMT = 4'd6;
  localparam logic [REG_AW-1:0] A_CAP_DHI  = 4'd7;
  localparam logic [REG_AW-1:0] A_CAP_DLO  = 4'd8;
  localparam logic [REG_AW-1:0] A_CAP_CHK  = 4'd9;
  localparam logic [REG_AW-1:0] A_CAP_ALO  = 4'd10;
  localparam logic [REG_AW-1:0] A_CAP_AHI  = 4'd11;

  // bit 0: correctable, bit 1: uncorrectable
  typedef struct packed {
    logic mbe;
    logic sbe;
  } err_pair_t;
endpackage

// File: rtl/mem_err_inject.sv
module mem_err_inject #(
  parameter int DW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] mask_data,
  input  logic [CW-1:0] mask_chk,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_chk,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_chk
);
  logic [DW-1:0] flip_d;
  logic [CW-1:0] flip_c;

  always_comb begin
    flip_d = en ? mask_data : '0;
    flip_c = en ? mask_chk  : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chk   <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_data ^ flip_d;
      out_chk   <= in_chk ^ flip_c;
    end
  end
endmodule

// File: rtl/mem_err_sbe_count.sv
module mem_err_sbe_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W:0] inc;
  logic [CNT_W:0] eff_thr;

  always_comb begin
    inc     = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    eff_thr = (thr == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, thr};
    hit     = ev && (inc >= eff_thr);
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (ev)  cnt <= hit ? '0 : inc[CNT_W-1:0];
  end
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture #(
  parameter int DW  = 64,
  parameter int CW  = 16,
  parameter int NCW = 8,
  parameter int AW  = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          bus32,
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] chk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] cap_data,
  output logic [CW-1:0] cap_chk,
  output logic [AW-1:0] cap_addr
);
  logic [CW-1:0] keep;

  for (genvar i = 0; i < CW; i++) begin : g_keep
    if (i < NCW) begin : g_low
      assign keep[i] = 1'b1;
    end else begin : g_high
      assign keep[i] = bus32;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data <= '0;
      cap_chk  <= '0;
      cap_addr <= '0;
    end else if (take) begin
      cap_data <= data;
      cap_chk  <= chk & keep;
      cap_addr <= addr;
    end
  end
endmodule

// File: rtl/mem_err_unit.sv
module mem_err_unit import mem_err_pkg::*; #(
  parameter int REG_W   = 32,
  parameter int CHK_W   = 16,
  parameter int NCHK_W  = 8,
  parameter int FADDR_W = 64,
  parameter int CNT_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_bus32,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 wr_valid_in,
  input  logic [2*REG_W-1:0]   wr_data_in,
  input  logic [CHK_W-1:0]     wr_chk_in,
  output logic                 wr_valid_out,
  output logic [2*REG_W-1:0]   wr_data_out,
  output logic [CHK_W-1:0]     wr_chk_out,
  input  logic                 chk_valid,
  input  logic                 chk_sbe,
  input  logic                 chk_mbe,
  input  logic [2*REG_W-1:0]   chk_data,
  input  logic [CHK_W-1:0]     chk_ecc,
  input  logic [FADDR_W-1:0]   chk_addr,
  output logic                 irq
);
  localparam int DATA_W = 2 * REG_W;
  localparam int HALF_A = FADDR_W / 2;

  logic [REG_W-1:0]   mask_hi_q, mask_lo_q;
  logic [CHK_W-1:0]   inj_chk_q;
  logic               inj_en_q;
  err_pair_t          detect_q, dis_q, ien_q;
  err_pair_t          set_v, clr_v;
  logic [CNT_W-1:0]   thr_q, sbe_cnt;
  logic               sbe_ev, sbe_hit, mbe_ev, take, mgmt_ld;
  logic [DATA_W-1:0]  cap_data;
  logic [CHK_W-1:0]   cap_chk;
  logic [FADDR_W-1:0] cap_addr;
  logic [REG_W-1:0]   rd_mux;

  function automatic logic wsel(input logic [REG_AW-1:0] a);
    return reg_wr && (reg_addr == a);
  endfunction

  always_comb begin
    sbe_ev  = chk_valid && chk_sbe && !dis_q.sbe;
    mbe_ev  = chk_valid && chk_mbe && !dis_q.mbe;
    set_v   = '{mbe: mbe_ev, sbe: sbe_hit};
    clr_v   = wsel(A_DETECT) ? err_pair_t'(reg_wdata[1:0]) : '0;
    take    = (detect_q == '0) && (set_v != '0);
    mgmt_ld = wsel(A_SBE_MGMT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      inj_chk_q <= '0;
      inj_en_q  <= 1'b0;
      dis_q     <= '0;
      ien_q     <= '0;
      thr_q     <= '0;
    end else begin
      if (wsel(A_MASK_HI)) mask_hi_q <= reg_wdata;
      if (wsel(A_MASK_LO)) mask_lo_q <= reg_wdata;
      if (wsel(A_INJ_CTL)) begin
        inj_chk_q <= reg_wdata[CHK_W-1:0];
        inj_en_q  <= reg_wdata[CHK_W];
      end
      if (wsel(A_DISABLE)) dis_q <= err_pair_t'(reg_wdata[1:0]);
      if (wsel(A_IRQ_EN))  ien_q <= err_pair_t'(reg_wdata[1:0]);
      if (mgmt_ld)         thr_q <= reg_wdata[THR_LSB +: CNT_W];
    end
  end

  // flags: clear by write-one, set has priority
  always_ff @(posedge clk) begin
    if (rst) detect_q <= '0;
    else     detect_q <= (detect_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(detect_q & ien_q);
  end

  mem_err_sbe_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .ev     (sbe_ev),
    .ld     (mgmt_ld),
    .ld_val (reg_wdata[CNT_W-1:0]),
    .thr    (thr_q),
    .cnt    (sbe_cnt),
    .hit    (sbe_hit)
  );

  mem_err_capture #(.DW(DATA_W), .CW(CHK_W), .NCW(NCHK_W), .AW(FADDR_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .bus32    (cfg_bus32),
    .data     (chk_data),
    .chk      (chk_ecc),
    .addr     (chk_addr),
    .cap_data (cap_data),
    .cap_chk  (cap_chk),
    .cap_addr (cap_addr)
  );

  mem_err_inject #(.DW(DATA_W), .CW(CHK_W)) u_inj (
    .clk       (clk),
    .rst       (rst),
    .en        (inj_en_q),
    .mask_data ({mask_hi_q, mask_lo_q}),
    .mask_chk  (inj_chk_q),
    .in_valid  (wr_valid_in),
    .in_data   (wr_data_in),
    .in_chk    (wr_chk_in),
    .out_valid (wr_valid_out),
    .out_data  (wr_data_out),
    .out_chk   (wr_chk_out)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_MASK_HI:  rd_mux = mask_hi_q;
      A_MASK_LO:  rd_mux = mask_lo_q;
      A_INJ_CTL:  begin
        rd_mux[CHK_W-1:0] = inj_chk_q;
        rd_mux[CHK_W]     = inj_en_q;
      end
      A_DETECT:   rd_mux[1:0] = detect_q;
      A_DISABLE:  rd_mux[1:0] = dis_q;
      A_IRQ_EN:   rd_mux[1:0] = ien_q;
      A_SBE_MGMT: begin
        rd_mux[THR_LSB +: CNT_W] = thr_q;
        rd_mux[CNT_W-1:0]        = sbe_cnt;
      end
      A_CAP_DHI:  rd_mux = cap_data[DATA_W-1:REG_W];
      A_CAP_DLO:  rd_mux = cap_data[REG_W-1:0];
      A_CAP_CHK:  rd_mux[CHK_W-1:0] = cap_chk;
      A_CAP_ALO:  rd_mux = REG_W'(cap_addr[HALF_A-1:0]);
      A_CAP_AHI:  rd_mux = REG_W'(cap_addr[FADDR_W-1:HALF_A]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mem_err_unit_chk.sv
module mem_err_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  reg_addr,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [1:0]  detect,
  input logic [1:0]  dis,
  input logic [1:0]  ien,
  input logic        chk_valid,
  input logic        chk_mbe,
  input logic [63:0] cap_data,
  input logic        inj_on,
  input logic        wr_valid_in,
  input logic [63:0] wr_data_in,
  input logic        wr_valid_out,
  input logic [63:0] wr_data_out,
  input logic        irq
);
  // R7
  mbe_flag_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid && chk_mbe && !dis[1] |=> detect[1]);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == 4'd3 && reg_wdata[1] && !(chk_valid && chk_mbe && !dis[1])
    |=> !detect[1]);

  // R8
  cap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (|detect) |=> $stable(cap_data));

  // R2
  inj_off_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid_in && !inj_on |=> wr_data_out == $past(wr_data_in));

  // R2
  wr_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid_in |=> wr_valid_out);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(detect & ien)));

  // R4
  sbe_masked_chk: assert property (@(posedge clk) disable iff (rst)
    dis[0] && !detect[0] |=> !detect[0]);
endmodule

bind mem_err_unit mem_err_unit_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .detect       (detect_q),
  .dis          (dis_q),
  .ien          (ien_q),
  .chk_valid    (chk_valid),
  .chk_mbe      (chk_mbe),
  .cap_data     (cap_data),
  .inj_on       (inj_en_q),
  .wr_valid_in  (wr_valid_in),
  .wr_data_in   (wr_data_in),
  .wr_valid_out (wr_valid_out),
  .wr_data_out  (wr_data_out),
  .irq          (irq)
);

// File: tb/mem_err_unit_test.sv
module mem_err_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_bus32 = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wr_valid_in = 1'b0;
  logic [63:0] wr_data_in = '0;
  logic [15:0] wr_chk_in = '0;
  logic        wr_valid_out;
  logic [63:0] wr_data_out;
  logic [15:0] wr_chk_out;
  logic        chk_valid = 1'b0, chk_sbe = 1'b0, chk_mbe = 1'b0;
  logic [63:0] chk_data = '0;
  logic [15:0] chk_ecc = '0;
  logic [63:0] chk_addr = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mem_err_unit uut (.*);

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_hi, m_lo, m_rd;
  logic [16:0] m_ic;
  logic [1:0]  m_det, m_dis, m_ien;
  logic [7:0]  m_thr;
  int          m_cnt;
  logic [63:0] m_cd, m_ca, m_wd;
  logic [15:0] m_cc, m_wc;
  logic        m_irq, m_wv, m_rv, s_set, b_set, armed;
  logic [3:0]  m_ra;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0:  return m_hi;
      4'd1:  return m_lo;
      4'd2:  return {15'd0, m_ic};
      4'd3:  return {30'd0, m_det};
      4'd4:  return {30'd0, m_dis};
      4'd5:  return {30'd0, m_ien};
      4'd6:  return {8'd0, m_thr, 8'd0, 8'(m_cnt)};
      4'd7:  return m_cd[63:32];
      4'd8:  return m_cd[31:0];
      4'd9:  return {16'd0, m_cc};
      4'd10: return m_ca[31:0];
      4'd11: return m_ca[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2: return "R1";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd9: return "R9";
      4'd7, 4'd8, 4'd10, 4'd11: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hi = 0; m_lo = 0; m_ic = 0; m_det = 0; m_dis = 0; m_ien = 0;
      m_thr = 0; m_cnt = 0; m_cd = 0; m_ca = 0; m_cc = 0;
      m_irq = 0; m_wv = 0; m_wd = 0; m_wc = 0; m_rv = 0; m_rd = 0; m_ra = 0;
    end else begin
      m_rv = reg_rd;
      m_ra = reg_addr;
      if (reg_rd) m_rd = model_read(reg_addr);
      m_irq = |(m_det & m_ien);
      m_wv  = wr_valid_in;
      m_wd  = wr_data_in ^ (m_ic[16] ? {m_hi, m_lo} : 64'd0);
      m_wc  = wr_chk_in ^ (m_ic[16] ? m_ic[15:0] : 16'd0);
      armed = (m_det == 2'b00);
      s_set = 0;
      if (chk_valid && chk_sbe && !m_dis[0]) begin
        m_cnt = m_cnt + 1;
        if (m_cnt >= ((m_thr == 0) ? 1 : int'(m_thr))) begin
          s_set = 1;
          m_cnt = 0;
        end
      end
      b_set = chk_valid && chk_mbe && !m_dis[1];
      if (reg_wr) begin
        case (reg_addr)
          4'd0: m_hi = reg_wdata;
          4'd1: m_lo = reg_wdata;
          4'd2: m_ic = reg_wdata[16:0];
          4'd3: m_det = m_det & ~reg_wdata[1:0];
          4'd4: m_dis = reg_wdata[1:0];
          4'd5: m_ien = reg_wdata[1:0];
          4'd6: begin m_thr = reg_wdata[23:16]; m_cnt = int'(reg_wdata[7:0]); end
          default: ;
        endcase
      end
      m_det = m_det | {b_set, s_set};
      if (armed && (s_set || b_set)) begin
        m_cd = chk_data;
        m_ca = chk_addr;
        m_cc = cfg_bus32 ? chk_ecc : {8'd0, chk_ecc[7:0]};
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R5 irq: got %b expected %b", irq, m_irq);
      end
      checks++;
      if (wr_valid_out !== m_wv || (m_wv && (wr_data_out !== m_wd || wr_chk_out !== m_wc))) begin
        errors++;
        $display("FAIL R2 write path: got %b/%h/%h expected %b/%h/%h",
                 wr_valid_out, wr_data_out, wr_chk_out, m_wv, m_wd, m_wc);
      end
      if (m_rv) begin
        checks++;
        if (reg_rdata !== m_rd) begin
          errors++;
          $display("FAIL %s read addr %0d: got %h expected %h",
                   tag_of(m_ra), m_ra, reg_rdata, m_rd);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic expect32(input string tag, input string what,
                          input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp,
                           input string tag, input string what);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    expect32(tag, what, reg_rdata, exp);
  endtask

  task automatic err_ev(input logic s, input logic m, input logic [63:0] d,
                        input logic [15:0] e, input logic [63:0] ad);
    @(negedge clk);
    chk_valid = 1'b1; chk_sbe = s; chk_mbe = m;
    chk_data = d; chk_ecc = e; chk_addr = ad;
    @(negedge clk);
    chk_valid = 1'b0; chk_sbe = 1'b0; chk_mbe = 1'b0;
  endtask

  task automatic beat(input logic [63:0] d, input logic [15:0] c,
                      input logic [63:0] exp_d, input logic [15:0] exp_c, input string what);
    @(negedge clk);
    wr_valid_in = 1'b1; wr_data_in = d; wr_chk_in = c;
    @(negedge clk);
    wr_valid_in = 1'b0;
    expect32("R2", {what, " valid"}, {31'd0, wr_valid_out}, 32'd1);
    expect32("R2", {what, " data hi"}, wr_data_out[63:32], exp_d[63:32]);
    expect32("R2", {what, " data lo"}, wr_data_out[31:0], exp_d[31:0]);
    expect32("R2", {what, " chk"}, {16'd0, wr_chk_out}, {16'd0, exp_c});
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state and unmapped read
    for (int a = 0; a < 16; a++) rd_expect(4'(a), 32'd0, "R10", "reset value");
    expect32("R5", "irq after reset", {31'd0, irq}, 32'd0);

    // R1 mask registers
    wr(4'd0, 32'hF000_0001);
    wr(4'd1, 32'h0000_0080);
    wr(4'd2, 32'h0000_0003);
    rd_expect(4'd0, 32'hF000_0001, "R1", "upper mask");
    rd_expect(4'd1, 32'h0000_0080, "R1", "lower mask");
    rd_expect(4'd2, 32'h0000_0003, "R1", "inject control");

    // R2 pass-through, then injection on
    beat(64'h1234_5678_9ABC_DEF0, 16'h00AA, 64'h1234_5678_9ABC_DEF0, 16'h00AA, "inject off");
    wr(4'd2, 32'h0001_0003);
    beat(64'h1234_5678_9ABC_DEF0, 16'h00AA, 64'hE234_5679_9ABC_DE70, 16'h00A9, "inject on");
    wr(4'd2, 32'h0000_0000);

    // R6 threshold 3, R8 capture, R9 64-bit bus masking
    wr(4'd6, 32'h0003_0000);
    err_ev(1, 0, 64'h1, 16'h0001, 64'h10);
    err_ev(1, 0, 64'h2, 16'h0002, 64'h20);
    rd_expect(4'd6, 32'h0003_0002, "R6", "count below threshold");
    rd_expect(4'd3, 32'd0, "R6", "no flag below threshold");
    err_ev(1, 0, 64'hDEAD_BEEF_0BAD_F00D, 16'hA5C3, 64'h0000_0001_2345_6780);
    rd_expect(4'd3, 32'd1, "R6", "flag at threshold");
    rd_expect(4'd6, 32'h0003_0000, "R6", "count reset after threshold");
    rd_expect(4'd7, 32'hDEAD_BEEF, "R8", "capture data hi");
    rd_expect(4'd8, 32'h0BAD_F00D, "R8", "capture data lo");
    rd_expect(4'd10, 32'h2345_6780, "R8", "capture addr lo");
    rd_expect(4'd11, 32'h0000_0001, "R8", "capture addr hi");
    rd_expect(4'd9, 32'h0000_00C3, "R9", "check field 64-bit bus");

    // R7 uncorrectable flag, R8 freeze, writes to capture ignored
    err_ev(0, 1, 64'h5555_5555_5555_5555, 16'h1111, 64'h99);
    rd_expect(4'd3, 32'd3, "R7", "uncorrectable flag");
    wr(4'd8, 32'hFFFF_FFFF);
    rd_expect(4'd8, 32'h0BAD_F00D, "R8", "capture frozen");

    // R5 interrupt gating
    wr(4'd5, 32'd2);
    @(negedge clk);
    expect32("R5", "irq with enable", {31'd0, irq}, 32'd1);

    // R3 write-one-to-clear
    wr(4'd3, 32'd0);
    rd_expect(4'd3, 32'd3, "R3", "write zero no effect");
    wr(4'd3, 32'd2);
    rd_expect(4'd3, 32'd1, "R3", "clear uncorrectable only");
    expect32("R5", "irq dropped", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'hFFFF_FFFF);
    rd_expect(4'd3, 32'd0, "R3", "all ones clears");

    // R8 re-arm after clear
    err_ev(0, 1, 64'hCAFE_0000_0000_BABE, 16'h0042, 64'h0000_0002_0000_0040);
    rd_expect(4'd8, 32'h0000_BABE, "R8", "capture re-armed");
    rd_expect(4'd11, 32'h0000_0002, "R8", "re-armed addr hi");
    wr(4'd3, 32'hFFFF_FFFF);

    // R4 disable, then R6 threshold 1
    wr(4'd6, 32'h0001_0000);
    wr(4'd4, 32'd3);
    err_ev(1, 1, 64'h7, 16'h7, 64'h7);
    rd_expect(4'd3, 32'd0, "R4", "disabled no flag");
    rd_expect(4'd6, 32'h0001_0000, "R4", "disabled no count");
    wr(4'd4, 32'd0);
    err_ev(1, 0, 64'h8, 16'h8, 64'h8);
    rd_expect(4'd3, 32'd1, "R6", "threshold 1 flags first");
    wr(4'd3, 32'd1);
    err_ev(1, 0, 64'h9, 16'h9, 64'h9);
    rd_expect(4'd3, 32'd1, "R6", "threshold 1 flags again");
    wr(4'd3, 32'd1);
    wr(4'd6, 32'h0000_0000);
    err_ev(1, 0, 64'hA, 16'hA, 64'hA);
    rd_expect(4'd3, 32'd1, "R6", "threshold 0 acts as 1");
    wr(4'd3, 32'd3);

    // R9 32-bit bus keeps 16 check bits
    cfg_bus32 = 1'b1;
    err_ev(0, 1, 64'h1, 16'hBEEF, 64'h1);
    rd_expect(4'd9, 32'h0000_BEEF, "R9", "check field 32-bit bus");
    cfg_bus32 = 1'b0;

    // R3 set wins over same-cycle clear
    wr(4'd3, 32'd3);
    @(negedge clk);
    reg_addr = 4'd3; reg_wdata = 32'd3; reg_wr = 1'b1;
    chk_valid = 1'b1; chk_mbe = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; chk_valid = 1'b0; chk_mbe = 1'b0;
    rd_expect(4'd3, 32'd2, "R3", "set beats clear");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule